// File: doc/BRIEF.md
# Configuration Image Header Ratio Detector

This block watches a 32-bit configuration data stream as it passes by and classifies the image from two fixed header words. It does not forward or alter the stream. Word 69 tells whether the image is encrypted, and word 229 tells whether it is compressed. Words are counted from 0 after the start-of-image strobe. When word 229 has been seen, the block combines both flags with the configured bus width (16 or 32 bits) and produces the 2-bit clock-to-data ratio code that the configuration engine needs.

An image shorter than 230 words cannot be classified. If the end-of-image strobe arrives before word 229 has been accepted, the block raises an error flag and gives no ratio. All results stay valid until the next start-of-image strobe.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset, encrypted_o, compressed_o, ratio_valid_o and short_err_o are 0, and ratio_o is 0.
- R2: encrypted_o is 1 when bit 3 or bit 2 of accepted word index 69 (counting from 0 after start of image) is set. It is 0 when both of those bits are 0, whatever the other bits hold.
- R3: compressed_o is 1 when bit 1 of accepted word index 229 is 0, and 0 when that bit is 1.
- R4: At 16-bit width the ratio code is 0 (x1) with neither flag set, 1 (x2) when encrypted only, and 2 (x4) when compressed, whether or not the image is encrypted.
- R5: At 32-bit width (width32_i = 1) the ratio code is 0 (x1) with neither flag set, 2 (x4) when encrypted only, and 3 (x8) when compressed. width32_i is sampled in the cycle that word 229 is accepted, and later changes do not alter ratio_o.
- R6: ratio_valid_o is high for exactly one cycle, in the cycle after word 229 is accepted. Words after 229 cause no further pulse and leave all flags unchanged.
- R7: start_i clears both flags, the ratio, the error and the word count. A word accepted in the same cycle as start_i is word 0 of the new image.
- R8: If end_i arrives while word 229 has not been accepted, short_err_o rises in the next cycle and stays high until start_i. ratio_valid_o does not assert for that image. If end_i comes in the same cycle as word 229, there is no error.
- R9: Cycles with valid_i low are not counted as words, and their data has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-image strobe |
| end_i | input | 1 | End-of-image strobe |
| valid_i | input | 1 | Stream word valid |
| data_i | input | 32 | Stream word |
| width32_i | input | 1 | Bus width select: 1 = 32-bit, 0 = 16-bit |
| encrypted_o | output | 1 | Image is encrypted |
| compressed_o | output | 1 | Image is compressed |
| ratio_o | output | 2 | Clock-to-data ratio code: 0 x1, 1 x2, 2 x4, 3 x8 |
| ratio_valid_o | output | 1 | One-cycle strobe when the ratio is ready |
| short_err_o | output | 1 | Image ended before the header was complete |

## Verification
Two pairs of functions can fall in the same cycle.

- End of image with the last header word: the bench ends an image with end_i on the very cycle that word 229 is accepted, and expects a ratio strobe with no error. An image that ends one word earlier must give the error and no strobe.
- Start of image with a word: the bench asserts start_i together with the first word, and expects that word to count as index 0.

A behavioural model built on a queue of accepted words predicts every output on every clock. Named checks confirm each scenario's final flags against the ratio table.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;
  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;
endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
  parameter int LAST_IDX = 229,
  parameter int CNT_W    = $clog2(LAST_IDX + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  output logic [CNT_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LAST_IDX);

  logic [CNT_W-1:0] cnt_q;

  // a word accepted with start is word 0
  assign idx_o = start_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (valid_i && (idx_o <= LAST))  cnt_q <= idx_o + 1'b1;
    else if (start_i)                     cnt_q <= '0;
  end

  assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST + 1'b1);

  assert_cnt_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [1:0]       enc_bits_i,
  input  logic             cmp_bit_i,
  output logic             enc_nxt_o,
  output logic             cmp_nxt_o,
  output logic             hit_o,
  output logic             enc_o,
  output logic             cmp_o,
  output logic             err_o
);
  logic enc_hit, done_q, done_nxt, err_nxt;

  assign enc_hit = valid_i && (idx_i == CNT_W'(ENC_IDX));
  assign hit_o   = valid_i && (idx_i == CNT_W'(CMP_IDX));

  assign enc_nxt_o = enc_hit ? |enc_bits_i : (start_i ? 1'b0 : enc_o);
  assign cmp_nxt_o = hit_o   ? ~cmp_bit_i  : (start_i ? 1'b0 : cmp_o);
  assign done_nxt  = hit_o | (!start_i & done_q);
  // end in the same cycle as the last header word is not an error
  assign err_nxt   = (end_i && !done_nxt) | (!start_i & err_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_o  <= 1'b0;
      cmp_o  <= 1'b0;
      done_q <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      enc_o  <= enc_nxt_o;
      cmp_o  <= cmp_nxt_o;
      done_q <= done_nxt;
      err_o  <= err_nxt;
    end
  end

  assert_err_short_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !done_q);

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);
endmodule

// File: rtl/hdr_ratio_map.sv
module hdr_ratio_map
  import hdr_ratio_pkg::*;
(
  input  logic   enc_i,
  input  logic   cmp_i,
  input  logic   wide_i,
  output ratio_e ratio_o
);
  always_comb begin
    if (!enc_i && !cmp_i) ratio_o = RATIO_X1;
    else if (cmp_i)       ratio_o = wide_i ? RATIO_X8 : RATIO_X4;
    else                  ratio_o = wide_i ? RATIO_X4 : RATIO_X2;
  end
endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect
  import hdr_ratio_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int CMP_IDX = 229,
  parameter int CMP_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              width32_i,
  output logic              encrypted_o,
  output logic              compressed_o,
  output logic [1:0]        ratio_o,
  output logic              ratio_valid_o,
  output logic              short_err_o
);
  localparam int LAST_IDX = (CMP_IDX > ENC_IDX) ? CMP_IDX : ENC_IDX;
  localparam int CNT_W    = $clog2(LAST_IDX + 2);

  logic [CNT_W-1:0] idx;
  logic             enc_nxt, cmp_nxt, hit;
  ratio_e           ratio_nxt, ratio_q;
  logic             rv_q;

  hdr_word_counter #(.LAST_IDX(LAST_IDX), .CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .start_i, .valid_i, .idx_o(idx)
  );

  hdr_flag_capture #(.ENC_IDX(ENC_IDX), .CMP_IDX(CMP_IDX), .CNT_W(CNT_W)) i_cap (
    .clk_i, .rst_ni, .start_i, .end_i, .valid_i,
    .idx_i      (idx),
    .enc_bits_i (data_i[ENC_LSB+1:ENC_LSB]),
    .cmp_bit_i  (data_i[CMP_BIT]),
    .enc_nxt_o  (enc_nxt),
    .cmp_nxt_o  (cmp_nxt),
    .hit_o      (hit),
    .enc_o      (encrypted_o),
    .cmp_o      (compressed_o),
    .err_o      (short_err_o)
  );

  hdr_ratio_map i_map (
    .enc_i(enc_nxt), .cmp_i(cmp_nxt), .wide_i(width32_i), .ratio_o(ratio_nxt)
  );

  // width sampled with the last header word only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RATIO_X1;
      rv_q    <= 1'b0;
    end else begin
      rv_q <= hit;
      if (hit)          ratio_q <= ratio_nxt;
      else if (start_i) ratio_q <= RATIO_X1;
    end
  end

  assign ratio_o       = ratio_q;
  assign ratio_valid_o = rv_q;

  assert_rv_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_valid_o |=> !ratio_valid_o);

  assert_rv_no_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_valid_o |-> !short_err_o);

  assert_plain_x1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_valid_o && !encrypted_o && !compressed_o) |-> (ratio_o == RATIO_X1));

  assert_cmp_ratio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_valid_o && compressed_o) |-> ratio_o[1]);

  assert_start_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_i && !end_i) |=>
      (!short_err_o && !encrypted_o && !compressed_o && !ratio_valid_o));

  assert_ratio_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit && !start_i) |=> $stable(ratio_o));
endmodule

// File: tb/test_hdr_ratio_detect.sv
`timescale 1ns/1ps
module test_hdr_ratio_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, fin = 1'b0, valid = 1'b0, w32 = 1'b0;
  logic [31:0] data = '0;
  logic        enc_o, cmp_o, rv_o, err_o;
  logic [1:0]  ratio_o;

  int n_chk = 0, n_fail = 0, rv_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hdr_ratio_detect i_hdr_ratio_detect (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .end_i(fin), .valid_i(valid),
    .data_i(data), .width32_i(w32), .encrypted_o(enc_o), .compressed_o(cmp_o),
    .ratio_o(ratio_o), .ratio_valid_o(rv_o), .short_err_o(err_o)
  );

  // behavioural reference model
  logic [31:0] img_q[$];
  bit          m_enc, m_cmp, m_rv, m_err, m_done;
  logic [1:0]  m_ratio;

  function automatic logic [1:0] ratio_table(bit e, bit c, bit w);
    case ({w, e, c})
      3'b000: return 2'd0; 3'b001: return 2'd2;
      3'b010: return 2'd1; 3'b011: return 2'd2;
      3'b100: return 2'd0; 3'b101: return 2'd3;
      3'b110: return 2'd2; default: return 2'd3;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q.delete();
      m_enc = 0; m_cmp = 0; m_rv = 0; m_err = 0; m_done = 0; m_ratio = 0;
    end else begin
      m_rv = 0;
      if (start) begin
        img_q.delete();
        m_enc = 0; m_cmp = 0; m_err = 0; m_done = 0; m_ratio = 0;
      end
      if (valid && img_q.size() < 230) begin
        if (img_q.size() == 69) m_enc = (data[3:2] != 2'b00);
        if (img_q.size() == 229) begin
          m_cmp = !data[1];
          m_ratio = ratio_table(m_enc, m_cmp, w32);
          m_rv = 1; m_done = 1;
        end
        img_q.push_back(data);
      end
      if (fin && !m_done) m_err = 1;
    end
  end

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 encrypted_o per cycle", {3'b0, enc_o}, {3'b0, m_enc});
      check("R3 compressed_o per cycle", {3'b0, cmp_o}, {3'b0, m_cmp});
      check("R4/R5 ratio_o per cycle", {2'b0, ratio_o}, {2'b0, m_ratio});
      check("R6 ratio_valid_o per cycle", {3'b0, rv_o}, {3'b0, m_rv});
      check("R8 short_err_o per cycle", {3'b0, err_o}, {3'b0, m_err});
      if (rv_o) rv_cnt++;
    end
  end

  function automatic logic [31:0] word_of(int k, logic [1:0] e, bit c);
    logic [31:0] w;
    w = (k * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    if (k == 69) w[3:2] = e;
    if (k == 229) w[1] = !c;
    return w;
  endfunction

  task automatic run_image(int n, logic [1:0] e, bit c, bit wide,
                           bit start_joined, bit end_joined, int gap);
    rv_cnt = 0;
    w32 = wide;
    if (!start_joined) begin
      start = 1; @(negedge clk); start = 0;
    end
    for (int k = 0; k < n; k++) begin
      if (gap != 0 && (k % gap) == gap - 1) begin
        valid = 0; data = 32'hFFFF_FFFF; @(negedge clk);  // R9 idle cycle
      end
      valid = 1;
      data  = word_of(k, e, c);
      start = start_joined && (k == 0);
      fin   = end_joined && (k == n - 1);
      w32   = (k > 229) ? !wide : wide;
      @(negedge clk);
    end
    valid = 0; start = 0; fin = 0; data = '0;
    if (!end_joined) begin
      fin = 1; @(negedge clk); fin = 0;
    end
    w32 = !wide;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_img(string tag, bit e, bit c, logic [1:0] r, bit er, int pulses);
    check({tag, " R2 encrypted"}, {3'b0, enc_o}, {3'b0, e});
    check({tag, " R3 compressed"}, {3'b0, cmp_o}, {3'b0, c});
    check({tag, " R4/R5 ratio"}, {2'b0, ratio_o}, {2'b0, r});
    check({tag, " R8 error"}, {3'b0, err_o}, {3'b0, er});
    check({tag, " R6 pulse count"}, 4'(rv_cnt), 4'(pulses));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset flags", {enc_o, cmp_o, rv_o, err_o}, 4'b0);
    check("R1 reset ratio", {2'b0, ratio_o}, 4'b0);

    run_image(231, 2'b00, 0, 0, 0, 0, 0); expect_img("R4 plain16", 0, 0, 2'd0, 0, 1);
    run_image(231, 2'b01, 0, 0, 0, 0, 0); expect_img("R4 enc16", 1, 0, 2'd1, 0, 1);
    run_image(240, 2'b10, 1, 0, 0, 0, 0); expect_img("R4 enccmp16", 1, 1, 2'd2, 0, 1);
    run_image(231, 2'b00, 1, 0, 0, 0, 0); expect_img("R3 cmp16", 0, 1, 2'd2, 0, 1);
    run_image(231, 2'b00, 0, 1, 0, 0, 0); expect_img("R5 plain32", 0, 0, 2'd0, 0, 1);
    run_image(235, 2'b11, 0, 1, 0, 0, 0); expect_img("R5 enc32", 1, 0, 2'd2, 0, 1);
    run_image(231, 2'b00, 1, 1, 0, 0, 0); expect_img("R5 cmp32", 0, 1, 2'd3, 0, 1);
    run_image(240, 2'b01, 1, 1, 0, 0, 7); expect_img("R9 gaps", 1, 1, 2'd3, 0, 1);
    run_image(229, 2'b01, 0, 0, 0, 0, 0); expect_img("R8 short", 1, 0, 2'd0, 1, 0);
    run_image(230, 2'b00, 1, 1, 0, 1, 0); expect_img("R8 end on last", 0, 1, 2'd3, 0, 1);
    run_image(229, 2'b00, 1, 1, 0, 1, 0); expect_img("R8 end one early", 0, 0, 2'd0, 1, 0);
    run_image(240, 2'b01, 0, 0, 1, 0, 0); expect_img("R7 joined start", 1, 0, 2'd1, 0, 1);
    run_image(50, 2'b11, 1, 0, 1, 1, 3); expect_img("R7 R8 tiny", 0, 0, 2'd0, 1, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule